// File: doc/BRIEF.md
# Presence-Detect Table Parser

This block reads the contents of a memory module's identification table one byte at a time and turns it into settings that a memory controller can use. Each byte comes in on a valid/ready stream together with its position in the table. The block checks the table's checksum and the memory-type code. It extracts the address geometry, the bank and rank counts, and the supported burst-length and read-latency masks. It also decodes the two packed cycle-time fields, and converts three nanosecond timing minimums into clock-cycle counts for a clock period given in tenths of a nanosecond.

The results are held in output registers. They all stay zero until the table has been parsed, and then they hold until reset. Only positions 0 to 127 matter. A byte with a higher position is taken from the stream and dropped. The producer is expected to send the bytes in ascending order, with position 127 last. A transfer takes place on a rising clock edge where `in_valid` and `in_ready` are both high. While the block is turning timings into cycles, `in_ready` is low. The producer must then hold `in_valid`, `in_index` and `in_data` steady until the transfer is taken. At all other times, including after `done`, `in_ready` is high. `period_tenths` must be held steady from the first byte until `done`.

Top module: `pd_table_parser`

## Requirements
- R1: The checksum fails when position 63 does not equal the low 8 bits of the sum of positions 0 to 62. When position 127 is taken with a failed checksum, `done` and `error` both go high after that edge, and every decoded output stays at zero.
- R2: A memory-type byte at position 2 other than 0x04 is treated the same way as a failed checksum: `done` and `error` go high, and the decoded outputs stay at zero.
- R3: On success, `row_bits`, `col_bits`, `rank_cnt` and `dev_banks` hold the bytes at positions 3, 4, 5 and 17.
- R4: On success, `burst_mask` holds position 16 (bits 0 to 3 mean burst lengths 1, 2, 4 and 8). `lat_mask` holds position 18 (bit n set means read latency n is supported).
- R5: Positions 9 and 23 carry whole nanoseconds in bits 7:4 and tenths in bits 3:0. `tck_a_tenths` and `tck_b_tenths` give each value as 10*upper + lower, in tenths of a nanosecond.
- R6: `trp_cyc`, `trcd_cyc` and `tras_cyc` equal ceil(10*N / `period_tenths`), where N is the whole-nanosecond byte at position 27, 29 or 30. A zero N gives 0. The count saturates at 255, and a zero period with nonzero N gives 255.
- R7: With a good table, `in_ready` is low from the edge that takes position 127 until `done` rises. `done` rises 3 + trp_cyc + trcd_cyc + tras_cyc edges after that edge, and `error` stays low.
- R8: Bytes with a position of 128 or more are accepted (`in_ready` high) and change no output.
- R9: After `done`, further bytes are accepted and ignored. All outputs hold until reset.
- R10: After reset, `done` and `error` are low, every decoded output is zero, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_tenths | input | 8 | Controller clock period in tenths of a nanosecond |
| in_valid | input | 1 | Producer has a table byte |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_index | input | 8 | Table position of the byte |
| in_data | input | 8 | Table byte value |
| done | output | 1 | Table fully processed (sticky) |
| error | output | 1 | Checksum or memory-type check failed |
| row_bits | output | 8 | Row address bit count |
| col_bits | output | 8 | Column address bit count |
| rank_cnt | output | 8 | Number of module ranks |
| dev_banks | output | 8 | Internal banks per device |
| burst_mask | output | 8 | Supported burst-length mask |
| lat_mask | output | 8 | Supported read-latency mask |
| tck_a_tenths | output | 8 | Cycle time at highest latency, tenths of ns |
| tck_b_tenths | output | 8 | Cycle time at next latency, tenths of ns |
| trp_cyc | output | 8 | Precharge time in cycles |
| trcd_cyc | output | 8 | Row-to-column delay in cycles |
| tras_cyc | output | 8 | Row-active time in cycles |

## Verification
The bench sends positions 130 and 131 in the middle of a table. A block that decoded only the low seven index bits would let them overwrite the type and row fields, and then flag an error or report the wrong geometry. A byte is held on the stream while the conversion runs. A block that took it during the stall, or miscounted the cycles before `done`, would diverge from the cycle-exact reference at that edge. A zero period, a one-tenth period and a zero timing byte exercise saturation and the zero case, where a divider that rounded down, wrapped or hung would show up. The corrupted-checksum and foreign-type tables confirm that nothing leaks to the outputs when a check fails.

// File: rtl/pd_parse_pkg.sv
package pd_parse_pkg;

  localparam int TABLE_LEN  = 128;
  localparam int CSUM_LAST  = 62;
  localparam int CSUM_POS   = 63;
  localparam int TYPE_SDR   = 8'h04;
  localparam int NF         = 12;

  // field slots held by the capture stage
  localparam int F_TYPE  = 0;
  localparam int F_ROWS  = 1;
  localparam int F_COLS  = 2;
  localparam int F_RANKS = 3;
  localparam int F_TCKA  = 4;
  localparam int F_BURST = 5;
  localparam int F_BANKS = 6;
  localparam int F_LAT   = 7;
  localparam int F_TCKB  = 8;
  localparam int F_TRP   = 9;
  localparam int F_TRCD  = 10;
  localparam int F_TRAS  = 11;

  typedef enum logic [1:0] {ST_COLLECT, ST_CONV, ST_DONE} st_e;

  // table position feeding each slot
  function automatic int slot_pos(input int slot);
    case (slot)
      F_TYPE:  return 2;
      F_ROWS:  return 3;
      F_COLS:  return 4;
      F_RANKS: return 5;
      F_TCKA:  return 9;
      F_BURST: return 16;
      F_BANKS: return 17;
      F_LAT:   return 18;
      F_TCKB:  return 23;
      F_TRP:   return 27;
      F_TRCD:  return 29;
      default: return 30;
    endcase
  endfunction

  // nibble-packed ns.tenths -> tenths
  function automatic logic [7:0] nib_to_tenths(input logic [7:0] b);
    return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
  endfunction

endpackage

// File: rtl/pd_csum_acc.sv
module pd_csum_acc
  import pd_parse_pkg::*;
#(
  parameter int DW   = 8,
  parameter int IDXW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [IDXW-1:0] idx,
  input  logic [DW-1:0]   data,
  output logic            match
);

  logic [DW-1:0] sum_q;
  logic [DW-1:0] ref_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q <= '0;
      ref_q <= '0;
    end else if (en) begin
      if (idx <= IDXW'(CSUM_LAST)) sum_q <= sum_q + data;
      if (idx == IDXW'(CSUM_POS))  ref_q <= data;
    end
  end

  assign match = (sum_q == ref_q);

endmodule

// File: rtl/pd_field_latch.sv
module pd_field_latch
  import pd_parse_pkg::*;
#(
  parameter int DW   = 8,
  parameter int IDXW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [IDXW-1:0]      idx,
  input  logic [DW-1:0]        data,
  output logic [NF-1:0][DW-1:0] fld
);

  for (genvar g = 0; g < NF; g++) begin : g_slot
    localparam int POS = slot_pos(g);
    always_ff @(posedge clk) begin
      if (!rst_n)                              fld[g] <= '0;
      else if (en && idx == IDXW'(POS))        fld[g] <= data;
    end
  end

endmodule

// File: rtl/pd_ceil_div.sv
module pd_ceil_div #(
  parameter int NW  = 12,
  parameter int DVW = 8,
  parameter int QW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [NW-1:0]  dividend,
  input  logic [DVW-1:0] divisor,
  output logic           busy,
  output logic           fin,
  output logic [QW-1:0]  quot
);

  localparam logic [QW-1:0] QMAX = '1;

  logic [NW-1:0] rem;

  assign fin = busy && ((rem == '0) || (quot == QMAX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      rem  <= '0;
      quot <= '0;
    end else if (start) begin
      busy <= 1'b1;
      rem  <= dividend;
      quot <= '0;
    end else if (busy) begin
      if (fin) begin
        busy <= 1'b0;
      end else begin
        rem  <= (rem > NW'(divisor)) ? rem - NW'(divisor) : '0;
        quot <= quot + 1'b1;
      end
    end
  end

  AST_DIV_REM_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin && !start && divisor != '0) |=> (rem < $past(rem))); // R6

endmodule

// File: rtl/pd_table_parser.sv
module pd_table_parser
  import pd_parse_pkg::*;
#(
  parameter int DW   = 8,
  parameter int IDXW = 8,
  parameter int CYCW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      period_tenths,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [IDXW-1:0] in_index,
  input  logic [DW-1:0]   in_data,
  output logic            done,
  output logic            error,
  output logic [DW-1:0]   row_bits,
  output logic [DW-1:0]   col_bits,
  output logic [DW-1:0]   rank_cnt,
  output logic [DW-1:0]   dev_banks,
  output logic [DW-1:0]   burst_mask,
  output logic [DW-1:0]   lat_mask,
  output logic [7:0]      tck_a_tenths,
  output logic [7:0]      tck_b_tenths,
  output logic [CYCW-1:0] trp_cyc,
  output logic [CYCW-1:0] trcd_cyc,
  output logic [CYCW-1:0] tras_cyc
);

  localparam int NSW   = DW + 4;
  localparam int NCONV = 3;

  st_e                  st;
  logic                 accept, col_en, last_hit, bad, csum_ok;
  logic [NF-1:0][DW-1:0] fld;
  logic                 div_start, div_busy, div_fin;
  logic [CYCW-1:0]      div_q;
  logic [NSW-1:0]       dividend;
  logic [DW-1:0]        ns_sel;
  logic [1:0]           fidx, div_sel;
  logic [CYCW-1:0]      stage0, stage1;

  assign in_ready = (st != ST_CONV);
  assign accept   = in_valid && in_ready;
  assign col_en   = accept && (st == ST_COLLECT) && (in_index < IDXW'(TABLE_LEN));
  assign last_hit = col_en && (in_index == IDXW'(TABLE_LEN - 1));

  pd_csum_acc #(.DW(DW), .IDXW(IDXW)) u_csum (
    .clk(clk), .rst_n(rst_n), .en(col_en), .idx(in_index), .data(in_data), .match(csum_ok)
  );

  pd_field_latch #(.DW(DW), .IDXW(IDXW)) u_fields (
    .clk(clk), .rst_n(rst_n), .en(col_en), .idx(in_index), .data(in_data), .fld(fld)
  );

  assign bad = !csum_ok || (fld[F_TYPE] != DW'(TYPE_SDR));

  // first conversion starts with the last byte; later ones chain on fin
  assign div_sel   = last_hit ? 2'd0 : fidx + 2'd1;
  assign div_start = (last_hit && !bad) || (div_fin && fidx != 2'(NCONV - 1));

  always_comb begin
    case (div_sel)
      2'd0:    ns_sel = fld[F_TRP];
      2'd1:    ns_sel = fld[F_TRCD];
      default: ns_sel = fld[F_TRAS];
    endcase
    dividend = NSW'(ns_sel) * NSW'(10);
  end

  pd_ceil_div #(.NW(NSW), .DVW(8), .QW(CYCW)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .dividend(dividend),
    .divisor(period_tenths), .busy(div_busy), .fin(div_fin), .quot(div_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= ST_COLLECT;
      fidx         <= '0;
      stage0       <= '0;
      stage1       <= '0;
      done         <= 1'b0;
      error        <= 1'b0;
      row_bits     <= '0;
      col_bits     <= '0;
      rank_cnt     <= '0;
      dev_banks    <= '0;
      burst_mask   <= '0;
      lat_mask     <= '0;
      tck_a_tenths <= '0;
      tck_b_tenths <= '0;
      trp_cyc      <= '0;
      trcd_cyc     <= '0;
      tras_cyc     <= '0;
    end else begin
      case (st)
        ST_COLLECT: begin
          if (last_hit) begin
            if (bad) begin
              st    <= ST_DONE;
              done  <= 1'b1;
              error <= 1'b1;
            end else begin
              st   <= ST_CONV;
              fidx <= '0;
            end
          end
        end
        ST_CONV: begin
          if (div_fin) begin
            fidx <= fidx + 2'd1;
            case (fidx)
              2'd0: stage0 <= div_q;
              2'd1: stage1 <= div_q;
              default: begin
                st           <= ST_DONE;
                done         <= 1'b1;
                row_bits     <= fld[F_ROWS];
                col_bits     <= fld[F_COLS];
                rank_cnt     <= fld[F_RANKS];
                dev_banks    <= fld[F_BANKS];
                burst_mask   <= fld[F_BURST];
                lat_mask     <= fld[F_LAT];
                tck_a_tenths <= nib_to_tenths(8'(fld[F_TCKA]));
                tck_b_tenths <= nib_to_tenths(8'(fld[F_TCKB]));
                trp_cyc      <= stage0;
                trcd_cyc     <= stage1;
                tras_cyc     <= div_q;
              end
            endcase
          end
        end
        default: ;
      endcase
    end
  end

  AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done); // R1

  AST_ERR_KEEPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (row_bits == '0 && col_bits == '0 && tras_cyc == '0 && trp_cyc == '0)); // R2

  AST_STALL_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> !done); // R7

  AST_DIV_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !div_busy); // R7

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && $stable(row_bits) && $stable(tras_cyc) && $stable(error))); // R9

endmodule

// File: tb/pd_table_parser_tb.sv
module pd_table_parser_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] period_tenths = 8'd75;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_index = '0;
  logic [7:0] in_data = '0;
  logic       done, error;
  logic [7:0] row_bits, col_bits, rank_cnt, dev_banks, burst_mask, lat_mask;
  logic [7:0] tck_a_tenths, tck_b_tenths, trp_cyc, trcd_cyc, tras_cyc;

  always #10 clk = ~clk;

  pd_table_parser dut_i (
    .clk(clk), .rst_n(rst_n), .period_tenths(period_tenths),
    .in_valid(in_valid), .in_ready(in_ready), .in_index(in_index), .in_data(in_data),
    .done(done), .error(error), .row_bits(row_bits), .col_bits(col_bits),
    .rank_cnt(rank_cnt), .dev_banks(dev_banks), .burst_mask(burst_mask),
    .lat_mask(lat_mask), .tck_a_tenths(tck_a_tenths), .tck_b_tenths(tck_b_tenths),
    .trp_cyc(trp_cyc), .trcd_cyc(trcd_cyc), .tras_cyc(tras_cyc)
  );

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R10";

  logic [7:0] tbl [128];
  int mem [128];
  int m_phase;
  int m_wait;
  bit m_acc;
  int exp_err;
  int exp_f [11];
  int pend_f [11];

  function automatic int ceil_cyc(input int ns, input int p);
    int q;
    if (ns == 0) return 0;
    if (p == 0) return 255;
    q = (ns * 10 + p - 1) / p;
    return (q > 255) ? 255 : q;
  endfunction

  function automatic int nib(input int b);
    return (b / 16) * 10 + (b % 16);
  endfunction

  task automatic chk(input string tag, input int act, input int expv, input string what);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, expv, $time);
    end
  endtask

  task automatic compare_all();
    int act [11];
    act = '{int'(row_bits), int'(col_bits), int'(rank_cnt), int'(dev_banks),
            int'(burst_mask), int'(lat_mask), int'(tck_a_tenths), int'(tck_b_tenths),
            int'(trp_cyc), int'(trcd_cyc), int'(tras_cyc)};
    chk("R7", int'(in_ready), (m_phase != 1) ? 1 : 0, "in_ready");
    chk("R7", int'(done), (m_phase == 2) ? 1 : 0, "done");
    chk(cur_req, int'(error), exp_err, "error");
    for (int i = 0; i < 11; i++) chk(cur_req, act[i], exp_f[i], $sformatf("field%0d", i));
  endtask

  // one clock: check outputs, drive inputs, advance the model to the next edge
  task automatic tick(input bit v, input int ix, input int d);
    int s;
    @(negedge clk);
    compare_all();
    in_valid = v;
    in_index = 8'(ix);
    in_data  = 8'(d);
    m_acc = v && (m_phase != 1);
    if (m_phase == 1) begin
      m_wait--;
      if (m_wait == 0) begin
        m_phase = 2;
        exp_f = pend_f;
      end
    end else if (m_phase == 0 && m_acc && ix < 128) begin
      mem[ix] = d;
      if (ix == 127) begin
        s = 0;
        for (int k = 0; k <= 62; k++) s += mem[k];
        if ((s % 256) != mem[63] || mem[2] != 4) begin
          m_phase = 2;
          exp_err = 1;
        end else begin
          pend_f = '{mem[3], mem[4], mem[5], mem[17], mem[16], mem[18],
                     nib(mem[9]), nib(mem[23]),
                     ceil_cyc(mem[27], period_tenths), ceil_cyc(mem[29], period_tenths),
                     ceil_cyc(mem[30], period_tenths)};
          m_phase = 1;
          m_wait = 3 + pend_f[8] + pend_f[9] + pend_f[10];
        end
      end
    end
  endtask

  task automatic push(input int ix, input int d);
    do tick(1'b1, ix, d); while (!m_acc);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    m_phase = 0;
    m_wait = 0;
    exp_err = 0;
    for (int i = 0; i < 11; i++) exp_f[i] = 0;
    for (int i = 0; i < 128; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic base_table(input int alt);
    for (int i = 0; i < 128; i++) tbl[i] = 8'((i * 37 + 11) % 256);
    tbl[2] = 8'h04;
    if (alt == 0) begin
      tbl[3] = 13; tbl[4] = 10; tbl[5] = 2; tbl[9] = 8'h75; tbl[16] = 8'h0F;
      tbl[17] = 4; tbl[18] = 8'h06; tbl[23] = 8'hA0; tbl[27] = 20; tbl[29] = 20; tbl[30] = 45;
    end else begin
      tbl[3] = 12; tbl[4] = 9; tbl[5] = 1; tbl[9] = 8'hA0; tbl[16] = 8'h03;
      tbl[17] = 2; tbl[18] = 8'h02; tbl[23] = 8'hF0; tbl[27] = 20; tbl[29] = 20; tbl[30] = 50;
    end
  endtask

  task automatic fix_sum();
    int s = 0;
    for (int k = 0; k <= 62; k++) s += tbl[k];
    tbl[63] = 8'(s % 256);
  endtask

  // stream a table; high-index bytes go in before the last byte, a stalled byte after it
  task automatic run_table(input int gaps);
    for (int i = 0; i < 127; i++) begin
      push(i, tbl[i]);
      if (gaps != 0 && (i % 5) == 0) tick(1'b0, 0, 0);
    end
    push(131, 8'h55);   // R8: would alias position 3 if the top index bit were dropped
    push(130, 8'h00);   // R8: would alias position 2
    push(127, tbl[127]);
    push(200, 8'hEE);   // R7: held across the conversion stall
    while (m_phase != 2) tick(1'b0, 0, 0);
    tick(1'b0, 0, 0);
    push(3, 8'h1F);     // R9: late byte after done
    push(30, 8'h01);    // R9
    repeat (3) tick(1'b0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R7 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R10: reset state
    do_reset();
    cur_req = "R10";
    repeat (3) tick(1'b0, 0, 0);

    // R3 R4 R5 R6 R8 R9: nominal table, 7.5 ns period
    cur_req = "R3/R4/R5/R6/R8/R9";
    period_tenths = 8'd75;
    base_table(0); fix_sum();
    run_table(0);

    // second geometry, 10 ns period, gaps in valid
    do_reset();
    cur_req = "R3/R4/R5/R6";
    period_tenths = 8'd100;
    base_table(1); fix_sum();
    run_table(1);

    // R1: corrupted checksum
    do_reset();
    cur_req = "R1";
    period_tenths = 8'd75;
    base_table(0); fix_sum();
    tbl[63] = tbl[63] + 8'd1;
    run_table(0);

    // R2: foreign memory type with a consistent checksum
    do_reset();
    cur_req = "R2";
    base_table(0);
    tbl[2] = 8'h07;
    fix_sum();
    run_table(0);

    // R6: zero period saturates, zero timing byte gives zero
    do_reset();
    cur_req = "R6";
    period_tenths = 8'd0;
    base_table(0);
    tbl[27] = 0;
    fix_sum();
    run_table(0);

    // R6: one-tenth period, large and capped counts
    do_reset();
    cur_req = "R6";
    period_tenths = 8'd1;
    base_table(0);
    tbl[29] = 10;
    fix_sum();
    run_table(0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule